// File: doc/BRIEF.md
# Landing Pad Fetch Checker

This block enforces forward-edge control-flow integrity at the instruction fetch stage. It keeps one bit of state that says whether the next fetched instruction must be a landing pad. The execute stage raises a strobe when an indirect jump that needs a landing pad retires, and that strobe arms the state. While the state is armed and the check is enabled, each valid fetch is examined. The block lets it through, or it replaces it with a software-check fault.

A fetched instruction counts as a landing pad only if four conditions hold. Its PC is word aligned. It is a full-width instruction. Its major opcode is 0010111 and its destination register field is zero. Its 20-bit label, held in instruction bits 31:12, is either zero or equal to bits 31:12 of register x7, which arrive on a separate input. A landing pad that meets all four conditions disarms the state. A fetch that fails any of them produces a fault with cause 18 and tval 2, and the state stays armed so that a trap handler can read it. A fetch that already carries an upstream error is forwarded without being checked.

Top module: `lpad_fetch_guard`

## Requirements
- R1: After reset `elp_o` is 0, and no fault is raised until the state has been armed.
- R2: While `lp_enable_i` is 0, every valid fetch passes (`result_pass_o`=1, `result_fault_o`=0), whatever the state.
- R3: While the state is 0, every valid fetch passes, whether it is compressed (`fetch_rvc_i`=1) or full width.
- R4: With the state at 1 and the check enabled, a valid error-free fetch whose PC bits 1:0 are not 00 faults.
- R5: With the state at 1 and the check enabled, a valid error-free compressed fetch faults.
- R6: With the state at 1 and the check enabled, an aligned full-width fetch faults unless instruction bits 6:0 equal 0010111 and bits 11:7 equal 00000.
- R7: For an aligned, well-formed landing pad, a label (instruction bits 31:12) of zero passes, a nonzero label equal to `x7_label_i` passes, and any other nonzero label faults.
- R8: A fault drives `fault_cause_o`=18 and `fault_tval_o`=2. When there is no fault, both outputs are 0.
- R9: A landing pad that passes every check clears the state at the next clock edge. A faulting fetch leaves the state at 1.
- R10: A valid fetch with `fetch_err_i`=1 passes unchecked and does not change the state.
- R11: `jump_expect_i` sets the state to 1 at the next edge. In the same cycle it takes precedence over a landing pad that would clear the state.
- R12: When `fetch_valid_i` is 0, both pass and fault are 0 and the state is changed by nothing except `jump_expect_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | A fetched instruction is presented |
| fetch_pc_i | input | XLEN | PC of the fetched instruction |
| fetch_insn_i | input | 32 | Instruction word (the low half carries a compressed instruction) |
| fetch_rvc_i | input | 1 | Instruction is 16-bit compressed |
| fetch_err_i | input | 1 | Fetch already carries an upstream error |
| lp_enable_i | input | 1 | Landing-pad checking enabled |
| x7_label_i | input | 20 | Bits 31:12 of register x7 |
| jump_expect_i | input | 1 | A qualifying indirect jump retired |
| result_valid_o | output | 1 | Result of this fetch is valid |
| result_pass_o | output | 1 | Fetch forwarded unchanged |
| result_fault_o | output | 1 | Fetch replaced by a software-check fault |
| fault_cause_o | output | CAUSE_W | Exception cause, 18 when faulting, otherwise 0 |
| fault_tval_o | output | XLEN | Trap value, 2 when faulting, otherwise 0 |
| elp_o | output | 1 | Current state, 1 when a landing pad is expected |

## Verification
The bench builds the block with its default parameters: a 32-bit XLEN, a 6-bit cause field and the cause and code values 18 and 2. These settings make the cause and tval encodings checkable as exact values. Because the label field is fixed at 20 bits, random labels drawn from zero, the x7 value and arbitrary values cover the wildcard, match and mismatch branches. Directed sequences cover the priority order, the case where a strobe and a clearing fetch arrive together, and the rule that a faulting fetch leaves the state armed.

// File: rtl/lpad_pkg.sv
package lpad_pkg;

    localparam int INSN_W    = 32;
    localparam int OPC_W     = 7;
    localparam int RD_LSB    = 7;
    localparam int RD_W      = 5;
    localparam int LABEL_LSB = 12;
    localparam int LABEL_W   = INSN_W - LABEL_LSB;

    localparam logic [OPC_W-1:0] LPAD_OPCODE = 7'b0010111;

    // Outcome of one fetch, listed in evaluation priority
    typedef enum logic [3:0] {
        LPV_IDLE        = 4'd0,  // no fetch presented
        LPV_PASS_ERR    = 4'd1,  // upstream error forwarded
        LPV_PASS_OFF    = 4'd2,  // checking disabled
        LPV_PASS_NOEXP  = 4'd3,  // nothing expected
        LPV_FAULT_ALIGN = 4'd4,  // misaligned PC
        LPV_FAULT_RVC   = 4'd5,  // compressed instruction
        LPV_FAULT_FMT   = 4'd6,  // wrong opcode or destination
        LPV_FAULT_LABEL = 4'd7,  // label mismatch
        LPV_PASS_LANDED = 4'd8   // valid landing pad consumed
    } lp_verdict_e;

    typedef struct packed {
        logic expected;
    } lp_state_t;

    function automatic logic verdict_faults(lp_verdict_e v);
        return (v == LPV_FAULT_ALIGN) || (v == LPV_FAULT_RVC) ||
               (v == LPV_FAULT_FMT)   || (v == LPV_FAULT_LABEL);
    endfunction

    function automatic logic verdict_passes(lp_verdict_e v);
        return (v != LPV_IDLE) && !verdict_faults(v);
    endfunction

endpackage

// File: rtl/lpad_insn_check.sv
module lpad_insn_check
    import lpad_pkg::*;
(
    input  logic                valid_i,
    input  logic                err_i,
    input  logic                enable_i,
    input  logic                expected_i,
    input  logic [1:0]          pc_lo_i,
    input  logic [INSN_W-1:0]   insn_i,
    input  logic                rvc_i,
    input  logic [LABEL_W-1:0]  x7_label_i,
    output lp_verdict_e         verdict_o
);

    logic [OPC_W-1:0]   opcode;
    logic [RD_W-1:0]    rd_field;
    logic [LABEL_W-1:0] label;
    logic               misaligned;
    logic               bad_format;
    logic               bad_label;

    always_comb begin
        opcode     = insn_i[OPC_W-1:0];
        rd_field   = insn_i[RD_LSB +: RD_W];
        label      = insn_i[LABEL_LSB +: LABEL_W];
        misaligned = (pc_lo_i != 2'b00);
        bad_format = (opcode != LPAD_OPCODE) || (rd_field != '0);
        bad_label  = (label != '0) && (label != x7_label_i);
    end

    // Fixed order: presence, error, enable, state, alignment, size, format, label
    always_comb begin
        if (!valid_i)           verdict_o = LPV_IDLE;
        else if (err_i)         verdict_o = LPV_PASS_ERR;
        else if (!enable_i)     verdict_o = LPV_PASS_OFF;
        else if (!expected_i)   verdict_o = LPV_PASS_NOEXP;
        else if (misaligned)    verdict_o = LPV_FAULT_ALIGN;
        else if (rvc_i)         verdict_o = LPV_FAULT_RVC;
        else if (bad_format)    verdict_o = LPV_FAULT_FMT;
        else if (bad_label)     verdict_o = LPV_FAULT_LABEL;
        else                    verdict_o = LPV_PASS_LANDED;
    end

endmodule

// File: rtl/lpad_state_reg.sv
module lpad_state_reg
    import lpad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic disarm_i,
    output logic expected_o
);

    lp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_i) begin
            st_d.expected = 1'b1;
        end else if (disarm_i) begin
            st_d.expected = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expected_o = st_q.expected;

endmodule

// File: rtl/lpad_fetch_guard.sv
module lpad_fetch_guard
    import lpad_pkg::*;
#(
    parameter int XLEN           = 32,
    parameter int CAUSE_W        = 6,
    parameter int SW_CHECK_CAUSE = 18,
    parameter int LP_FAULT_CODE  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_valid_i,
    input  logic [XLEN-1:0]      fetch_pc_i,
    input  logic [31:0]          fetch_insn_i,
    input  logic                 fetch_rvc_i,
    input  logic                 fetch_err_i,
    input  logic                 lp_enable_i,
    input  logic [19:0]          x7_label_i,
    input  logic                 jump_expect_i,
    output logic                 result_valid_o,
    output logic                 result_pass_o,
    output logic                 result_fault_o,
    output logic [CAUSE_W-1:0]   fault_cause_o,
    output logic [XLEN-1:0]      fault_tval_o,
    output logic                 elp_o
);

    localparam logic [CAUSE_W-1:0] CAUSE_VAL = CAUSE_W'(SW_CHECK_CAUSE);
    localparam logic [XLEN-1:0]    TVAL_VAL  = XLEN'(LP_FAULT_CODE);

    typedef struct packed {
        logic               valid;
        logic               pass;
        logic               fault;
        logic [CAUSE_W-1:0] cause;
        logic [XLEN-1:0]    tval;
    } lp_result_t;

    lp_verdict_e verdict;
    logic        expected;
    logic        disarm;
    lp_result_t  res_d;
    logic        pc_unused;

    assign pc_unused = ^fetch_pc_i[XLEN-1:2];

    lpad_insn_check u_check (
        .valid_i    (fetch_valid_i),
        .err_i      (fetch_err_i),
        .enable_i   (lp_enable_i),
        .expected_i (expected),
        .pc_lo_i    (fetch_pc_i[1:0]),
        .insn_i     (fetch_insn_i),
        .rvc_i      (fetch_rvc_i),
        .x7_label_i (x7_label_i),
        .verdict_o  (verdict)
    );

    assign disarm = (verdict == LPV_PASS_LANDED);

    lpad_state_reg u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (jump_expect_i),
        .disarm_i   (disarm),
        .expected_o (expected)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = fetch_valid_i;
        res_d.pass  = verdict_passes(verdict);
        res_d.fault = verdict_faults(verdict);
        if (res_d.fault) begin
            res_d.cause = CAUSE_VAL;
            res_d.tval  = TVAL_VAL;
        end
    end

    assign result_valid_o = res_d.valid;
    assign result_pass_o  = res_d.pass;
    assign result_fault_o = res_d.fault;
    assign fault_cause_o  = res_d.cause;
    assign fault_tval_o   = res_d.tval;
    assign elp_o          = expected;

endmodule

// File: rtl/lpad_fetch_guard_chk.sv
module lpad_fetch_guard_chk #(
    parameter int XLEN           = 32,
    parameter int CAUSE_W        = 6,
    parameter int SW_CHECK_CAUSE = 18,
    parameter int LP_FAULT_CODE  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_valid_i,
    input logic [XLEN-1:0]    fetch_pc_i,
    input logic [31:0]        fetch_insn_i,
    input logic               fetch_rvc_i,
    input logic               fetch_err_i,
    input logic               lp_enable_i,
    input logic [19:0]        x7_label_i,
    input logic               jump_expect_i,
    input logic               result_pass_o,
    input logic               result_fault_o,
    input logic [CAUSE_W-1:0] fault_cause_o,
    input logic [XLEN-1:0]    fault_tval_o,
    input logic               elp_o
);

    logic armed_fetch;
    logic good_shape;
    assign armed_fetch = fetch_valid_i && !fetch_err_i && lp_enable_i && elp_o;
    assign good_shape  = (fetch_pc_i[1:0] == 2'b00) && !fetch_rvc_i &&
                         (fetch_insn_i[6:0] == 7'b0010111) && (fetch_insn_i[11:7] == 5'd0);

    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> !elp_o);

    p_disabled_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && !lp_enable_i) |-> (result_pass_o && !result_fault_o));

    p_idle_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && !elp_o) |-> (result_pass_o && !result_fault_o));

    p_misalign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_fetch && fetch_pc_i[1:0] != 2'b00) |-> result_fault_o);

    p_compressed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_fetch && fetch_rvc_i) |-> result_fault_o);

    p_label_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_fetch && good_shape && fetch_insn_i[31:12] != 20'd0 &&
         fetch_insn_i[31:12] != x7_label_i) |-> result_fault_o);

    p_fault_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_fault_o |-> (fault_cause_o == CAUSE_W'(SW_CHECK_CAUSE) &&
                            fault_tval_o == XLEN'(LP_FAULT_CODE)));

    p_fault_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result_fault_o |=> elp_o);

    p_error_unchecked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && fetch_err_i && !jump_expect_i) |=>
        (!result_fault_o || $past(fetch_valid_i)) && $stable(elp_o));

    p_strobe_arms_r11: assert property (@(posedge clk) disable iff (!rst_n)
        jump_expect_i |=> elp_o);

    p_no_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid_i |-> (!result_pass_o && !result_fault_o));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid_i && !jump_expect_i) |=> $stable(elp_o));

endmodule

bind lpad_fetch_guard lpad_fetch_guard_chk #(
    .XLEN           (XLEN),
    .CAUSE_W        (CAUSE_W),
    .SW_CHECK_CAUSE (SW_CHECK_CAUSE),
    .LP_FAULT_CODE  (LP_FAULT_CODE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_valid_i  (fetch_valid_i),
    .fetch_pc_i     (fetch_pc_i),
    .fetch_insn_i   (fetch_insn_i),
    .fetch_rvc_i    (fetch_rvc_i),
    .fetch_err_i    (fetch_err_i),
    .lp_enable_i    (lp_enable_i),
    .x7_label_i     (x7_label_i),
    .jump_expect_i  (jump_expect_i),
    .result_pass_o  (result_pass_o),
    .result_fault_o (result_fault_o),
    .fault_cause_o  (fault_cause_o),
    .fault_tval_o   (fault_tval_o),
    .elp_o          (elp_o)
);

// File: tb/lpad_fetch_guard_tb.sv
module lpad_fetch_guard_tb;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;
    localparam int CAUSE_W    = 6;
    localparam logic [6:0] OPC = 7'b0010111;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              fv, frvc, ferr, en, jmp;
    logic [XLEN-1:0]   pc;
    logic [31:0]       insn;
    logic [19:0]       x7;
    logic              r_valid, r_pass, r_fault, elp;
    logic [CAUSE_W-1:0] cause;
    logic [XLEN-1:0]   tval;

    int checks   = 0;
    int failures = 0;
    logic model_st = 1'b0;
    string state_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    lpad_fetch_guard u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid_i(fv), .fetch_pc_i(pc),
        .fetch_insn_i(insn), .fetch_rvc_i(frvc), .fetch_err_i(ferr),
        .lp_enable_i(en), .x7_label_i(x7), .jump_expect_i(jmp),
        .result_valid_o(r_valid), .result_pass_o(r_pass), .result_fault_o(r_fault),
        .fault_cause_o(cause), .fault_tval_o(tval), .elp_o(elp)
    );

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference outcome: returns fault bit and the requirement that decided it
    function automatic logic ref_fault(logic v, logic e, logic n, logic st,
                                       logic [1:0] pl, logic c, logic [31:0] w,
                                       logic [19:0] lab, output string tag);
        tag = "R12";
        if (!v) return 1'b0;
        tag = "R10"; if (e)   return 1'b0;
        tag = "R2";  if (!n)  return 1'b0;
        tag = "R3";  if (!st) return 1'b0;
        tag = "R4";  if (pl != 2'b00) return 1'b1;
        tag = "R5";  if (c) return 1'b1;
        tag = "R6";  if (w[6:0] != OPC || w[11:7] != 5'd0) return 1'b1;
        tag = "R7";
        return (w[31:12] != 20'd0) && (w[31:12] != lab);
    endfunction

    task automatic step(logic v, logic [XLEN-1:0] p, logic [31:0] w, logic c,
                        logic e, logic n, logic [19:0] lab, logic j);
        string tag;
        logic  xf;
        @(negedge clk);
        check(state_tag, "elp_o", elp, model_st);
        fv = v; pc = p; insn = w; frvc = c; ferr = e; en = n; x7 = lab; jmp = j;
        #1;
        xf = ref_fault(v, e, n, model_st, p[1:0], c, w, lab, tag);
        check(tag, "fault", r_fault, xf);
        check(tag, "pass", r_pass, v && !xf);
        check("R12", "valid", r_valid, v);
        check("R8", "cause", cause, xf ? 18 : 0);
        check("R8", "tval", tval, xf ? 2 : 0);
        if (j) begin
            model_st = 1'b1; state_tag = "R11";
        end else if (v && !e && n && model_st && !xf) begin
            model_st = 1'b0; state_tag = "R9";
        end else begin
            state_tag = xf ? "R9" : (e ? "R10" : "R12");
        end
    endtask

    function automatic logic [31:0] lpad(logic [19:0] lab);
        return {lab, 5'd0, OPC};
    endfunction

    initial begin
        rst_n = 1'b0; fv = 0; pc = '0; insn = '0; frvc = 0; ferr = 0;
        en = 1; x7 = 20'h12345; jmp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "elp_o after reset", elp, 0);
        check("R1", "fault after reset", r_fault, 0);
        rst_n = 1'b1;

        // R3: idle state, junk instruction passes
        step(1, 32'h100, 32'hFFFF_FFFF, 0, 0, 1, 20'h12345, 0);
        step(1, 32'h102, 32'h0000_4501, 1, 0, 1, 20'h12345, 0);
        // R11: arm
        step(0, 0, 0, 0, 0, 1, 20'h12345, 1);
        // R4 misaligned landing pad, state held (R9)
        step(1, 32'h202, lpad(20'h0), 0, 0, 1, 20'h12345, 0);
        // R5 compressed
        step(1, 32'h200, lpad(20'h0), 1, 0, 1, 20'h12345, 0);
        // R6 opcode and rd
        step(1, 32'h200, {20'h0, 5'd0, 7'b0110111}, 0, 0, 1, 20'h12345, 0);
        step(1, 32'h200, {20'h0, 5'd3, OPC}, 0, 0, 1, 20'h12345, 0);
        // R7 label mismatch
        step(1, 32'h200, lpad(20'h12344), 0, 0, 1, 20'h12345, 0);
        // R10 error fetch unchecked
        step(1, 32'h203, 32'hDEAD_BEEF, 1, 1, 1, 20'h12345, 0);
        // R2 disabled
        step(1, 32'h201, 32'hDEAD_BEEF, 1, 0, 0, 20'h12345, 0);
        // R12 no fetch, landing pad bits present
        step(0, 32'h200, lpad(20'h0), 0, 0, 1, 20'h12345, 0);
        // R7 zero label wildcard, R9 clear
        step(1, 32'h200, lpad(20'h0), 0, 0, 1, 20'h12345, 0);
        step(1, 32'h204, 32'h1234_5678, 0, 0, 1, 20'h12345, 0);
        // R7 matching label
        step(0, 0, 0, 0, 0, 1, 20'h12345, 1);
        step(1, 32'h300, lpad(20'hABCDE), 0, 0, 1, 20'hABCDE, 0);
        // R11 strobe wins over clearing landing pad
        step(0, 0, 0, 0, 0, 1, 20'h12345, 1);
        step(1, 32'h400, lpad(20'h0), 0, 0, 1, 20'h12345, 1);
        step(1, 32'h404, lpad(20'h0), 0, 0, 1, 20'h12345, 0);

        void'($urandom(32'h1a2b3c4d));
        for (int i = 0; i < 4000; i++) begin
            logic [19:0] lab, xl;
            logic [31:0] w;
            logic [XLEN-1:0] p;
            int sel;
            xl  = 20'($urandom());
            sel = int'($urandom_range(0, 3));
            lab = (sel == 0) ? 20'd0 : (sel == 1) ? xl : 20'($urandom());
            w   = ($urandom_range(0, 3) != 0) ? lpad(lab) : $urandom();
            if ($urandom_range(0, 7) == 0) w[11:7] = 5'($urandom());
            p   = {$urandom()} & ((($urandom_range(0, 5)) == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFFC);
            step($urandom_range(0, 7) != 0, p, w, $urandom_range(0, 9) == 0,
                 $urandom_range(0, 11) == 0, $urandom_range(0, 9) != 0, xl,
                 $urandom_range(0, 2) == 0);
        end
        @(negedge clk);
        check(state_tag, "elp_o final", elp, model_st);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule